// File: doc/BRIEF.md
# Receiver Idle Timeout Detector

This block sits beside a UART receiver and measures the silence on the receive line between characters. After each character ends it counts oversampling ticks. When no new start bit arrives within a programmed number of bit periods plus a small fixed margin, it raises a sticky timeout flag. Software clears the flag by writing a one to the clear input.

The timeout is programmed in bit periods and is converted internally to sample ticks. There are 16 ticks per bit in normal oversampling and 8 ticks per bit when the 8x mode is selected. A two-tick margin is added to the converted value. Counting goes on while the receiver is disabled. The flag can only set while the receiver enable is high, so a gap that has already run out sets the flag as soon as the receiver is enabled. Each gap raises the flag at most once.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset the flag is low and no gap is being timed. Sample ticks before the first character-end pulse never set the flag.
- R2: A character-end pulse starts a gap with the tick count at zero. After exactly T×S ticks the flag is still low, where T is the programmed value and S is the ticks per bit.
- R3: The flag rises on the clock edge after the one on which the gap's tick count reaches T×S+2.
- R4: S is 16 when `os8_sel` is 0 and 8 when `os8_sel` is 1.
- R5: A start-detected pulse ends the gap, and no ticks are counted until the next character-end pulse. If both pulses arrive in the same cycle, the start-detected pulse wins. A new character-end pulse restarts the count from zero.
- R6: While `rx_en` is low, ticks are still counted but the flag never sets.
- R7: If the gap has already expired when `rx_en` is high, the flag sets on the next edge, including right after the enable rises.
- R8: The flag holds until `flag_clr` is high at a clock edge, which clears it. If a set and a clear happen in the same cycle, the set wins.
- R9: Once a gap has raised the flag, the flag stays low for the rest of that gap after being cleared. This holds even after the tick count saturates at its maximum, with no wrap.
- R10: With T = 0, the flag rises after two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One pulse per oversampling sample |
| char_end | input | 1 | Pulse at the end of a received character |
| start_det | input | 1 | Pulse when a start bit is detected |
| rx_en | input | 1 | Receiver enable; gates the flag setting |
| os8_sel | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| timeout_bits | input | TW | Timeout in bit periods |
| flag_clr | input | 1 | Write-1 clear of the flag |
| timeout_flag | output | 1 | Sticky timeout flag |

## Verification
The hardest condition to reach is saturation of the tick counter after a flag has already been raised and cleared. A wrap there would re-trigger the flag silently, and it needs a gap thousands of ticks long with no line activity. The stimulus clears the flag and then holds `sample_tick` high for more than the full counter range, so the count pins at its maximum while the flag output is watched. The enable-after-expiry case is reached by running a gap past its threshold with `rx_en` low and then raising the enable.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    // Extra ticks added beyond the programmed bit periods
    localparam int unsigned MARGIN_TICKS = 2;
    // log2 of ticks per bit in each oversampling mode
    localparam int unsigned SH_OS16 = 4;
    localparam int unsigned SH_OS8  = 3;

    typedef enum logic [1:0] {
        LINE_IDLE = 2'd0,   // no character seen since reset
        LINE_GAP  = 2'd1,   // between characters, timing silence
        LINE_RECV = 2'd2    // character in progress
    } line_e;

    typedef struct packed {
        logic set_req;
        logic clr_req;
    } flag_ctl_t;

    function automatic logic [2:0] tick_shift(input logic os8);
        return os8 ? 3'(SH_OS8) : 3'(SH_OS16);
    endfunction

endpackage

// File: rtl/rxto_gap_counter.sv
module rxto_gap_counter
    import rxto_pkg::*;
#(
    parameter int unsigned CW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_tick,
    input  logic          char_end,
    input  logic          start_det,
    output logic [CW-1:0] gap_cnt,
    output logic          in_gap
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    line_e line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q  <= LINE_IDLE;
            gap_cnt <= '0;
        end else if (start_det) begin
            line_q  <= LINE_RECV;
            gap_cnt <= '0;
        end else if (char_end) begin
            line_q  <= LINE_GAP;
            gap_cnt <= '0;
        end else if (line_q == LINE_GAP && sample_tick && gap_cnt != CNT_MAX) begin
            gap_cnt <= gap_cnt + 1'b1;
        end
    end

    assign in_gap = (line_q == LINE_GAP);

endmodule

// File: rtl/rxto_threshold.sv
module rxto_threshold
    import rxto_pkg::*;
#(
    parameter int unsigned TW = 8,
    parameter int unsigned CW = 13
) (
    input  logic [TW-1:0] timeout_bits,
    input  logic          os8_sel,
    input  logic [CW-1:0] gap_cnt,
    input  logic          in_gap,
    output logic [CW-1:0] thr_ticks,
    output logic          expired
);

    logic [CW-1:0] base_ticks;

    always_comb begin
        base_ticks = {{(CW-TW){1'b0}}, timeout_bits} << tick_shift(os8_sel);
        thr_ticks  = base_ticks + CW'(MARGIN_TICKS);
        expired    = in_gap && (gap_cnt >= thr_ticks);
    end

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag
    import rxto_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic expired,
    input  logic rx_en,
    input  logic char_end,
    input  logic start_det,
    input  logic flag_clr,
    output logic flag
);

    flag_ctl_t ctl;
    logic      fired_q;

    always_comb begin
        ctl.set_req = expired && rx_en && !fired_q;
        ctl.clr_req = flag_clr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag    <= 1'b0;
            fired_q <= 1'b0;
        end else begin
            if (ctl.set_req)
                flag <= 1'b1;
            else if (ctl.clr_req)
                flag <= 1'b0;

            if (start_det || char_end)
                fired_q <= 1'b0;
            else if (ctl.set_req)
                fired_q <= 1'b1;
        end
    end

endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
    import rxto_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sample_tick,
    input  logic          char_end,
    input  logic          start_det,
    input  logic          rx_en,
    input  logic          os8_sel,
    input  logic [TW-1:0] timeout_bits,
    input  logic          flag_clr,
    output logic          timeout_flag
);

    // Holds TW bits shifted by four plus the margin, with headroom to saturate
    localparam int unsigned CW = TW + 5;

    logic [CW-1:0] gap_cnt;
    logic [CW-1:0] thr_ticks;
    logic          in_gap;
    logic          expired;

    rxto_gap_counter #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .sample_tick (sample_tick),
        .char_end    (char_end),
        .start_det   (start_det),
        .gap_cnt     (gap_cnt),
        .in_gap      (in_gap)
    );

    rxto_threshold #(.TW(TW), .CW(CW)) u_thr (
        .timeout_bits (timeout_bits),
        .os8_sel      (os8_sel),
        .gap_cnt      (gap_cnt),
        .in_gap       (in_gap),
        .thr_ticks    (thr_ticks),
        .expired      (expired)
    );

    rxto_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .expired   (expired),
        .rx_en     (rx_en),
        .char_end  (char_end),
        .start_det (start_det),
        .flag_clr  (flag_clr),
        .flag      (timeout_flag)
    );

endmodule

// File: rtl/rx_idle_timeout_chk.sv
module rx_idle_timeout_chk #(
    parameter int unsigned CW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_en,
    input logic          flag_clr,
    input logic          char_end,
    input logic          start_det,
    input logic          flag,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] thr
);

    localparam logic [CW-1:0] CMAX = '1;

    p_reset_low_r1: assert property (@(posedge clk) rst |=> !flag)
        else $error("flag not low after reset");

    p_no_early_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(cnt) >= $past(thr)))
        else $error("flag rose before threshold");

    p_start_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (start_det || char_end) |=> (cnt == '0))
        else $error("count not restarted");

    p_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !flag) |=> !flag)
        else $error("flag set while disabled");

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag)
        else $error("flag dropped without clear");

    p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt == CMAX && !char_end && !start_det) |=> (cnt == CMAX))
        else $error("count wrapped");

endmodule

bind rx_idle_timeout rx_idle_timeout_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .flag_clr  (flag_clr),
    .char_end  (char_end),
    .start_det (start_det),
    .flag      (timeout_flag),
    .cnt       (gap_cnt),
    .thr       (thr_ticks)
);

// File: tb/rx_idle_timeout_bench.sv
module rx_idle_timeout_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 8;
    localparam int CNT_CAP = (1 << (TW + 5)) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_tick = 1'b0, char_end = 1'b0, start_det = 1'b0;
    logic rx_en = 1'b1, os8_sel = 1'b0, flag_clr = 1'b0;
    logic [TW-1:0] timeout_bits = '0;
    logic timeout_flag;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";

    // behavioural model state
    int  m_mode = 0;      // 0 none, 1 gap, 2 receiving
    int  m_cnt  = 0;
    bit  m_fired = 0;
    bit  m_flag  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_idle_timeout #(.TW(TW)) u_rx_idle_timeout (
        .clk(clk), .rst(rst), .sample_tick(sample_tick), .char_end(char_end),
        .start_det(start_det), .rx_en(rx_en), .os8_sel(os8_sel),
        .timeout_bits(timeout_bits), .flag_clr(flag_clr), .timeout_flag(timeout_flag)
    );

    always @(posedge clk) begin
        int limit;
        bit ev;
        limit = int'(timeout_bits) * (os8_sel ? 8 : 16) + 2;
        if (rst) begin
            m_mode = 0; m_cnt = 0; m_fired = 0; m_flag = 0;
        end else begin
            ev = (m_mode == 1) && (m_cnt >= limit) && rx_en && !m_fired;
            if (ev) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (start_det || char_end) m_fired = 0;
            else if (ev) m_fired = 1;
            if (start_det) begin m_mode = 2; m_cnt = 0; end
            else if (char_end) begin m_mode = 1; m_cnt = 0; end
            else if (m_mode == 1 && sample_tick && m_cnt < CNT_CAP) m_cnt++;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_tests++;
            if (timeout_flag !== m_flag) begin
                n_fail++;
                $display("FAIL %s model compare: actual=%0b expected=%0b", cur_req, timeout_flag, m_flag);
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string req);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        sample_tick = 1'b1;
        repeat (n) @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic pulse_end();
        char_end = 1'b1; @(negedge clk); char_end = 1'b0;
    endtask

    task automatic pulse_start();
        start_det = 1'b1; @(negedge clk); start_det = 1'b0;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        timeout_bits = 8'd3;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state and ticks before any character
        cur_req = "R1";
        check(timeout_flag, 1'b0, "R1 reset");
        ticks(100); idle(1);
        check(timeout_flag, 1'b0, "R1 no gap before first char");

        // R2 / R3: T=3, 16x -> 48 ticks quiet, flag after 50
        cur_req = "R2";
        pulse_end(); ticks(48); idle(1);
        check(timeout_flag, 1'b0, "R2 exact gap");
        cur_req = "R3";
        ticks(2);
        check(timeout_flag, 1'b0, "R3 before registered");
        idle(1);
        check(timeout_flag, 1'b1, "R3 set after margin");

        // R8: hold then clear
        cur_req = "R8";
        idle(5);
        check(timeout_flag, 1'b1, "R8 hold");
        pulse_clr();
        check(timeout_flag, 1'b0, "R8 cleared");

        // R4: 8x mode, threshold 26, sparse ticks
        cur_req = "R4";
        os8_sel = 1'b1;
        pulse_end();
        for (int i = 0; i < 25; i++) begin ticks(1); idle(1); end
        check(timeout_flag, 1'b0, "R4 8x below");
        ticks(1); idle(1);
        check(timeout_flag, 1'b1, "R4 8x set");
        pulse_clr();
        os8_sel = 1'b0;

        // R5: start detect stops counting; char end restarts from zero
        cur_req = "R5";
        pulse_end(); ticks(40); pulse_start(); ticks(100); idle(1);
        check(timeout_flag, 1'b0, "R5 no count in char");
        char_end = 1'b1; start_det = 1'b1; @(negedge clk); char_end = 1'b0; start_det = 1'b0;
        ticks(100); idle(1);
        check(timeout_flag, 1'b0, "R5 start wins over end");
        pulse_end(); ticks(49); idle(1);
        check(timeout_flag, 1'b0, "R5 restart from zero");
        ticks(1); idle(1);
        check(timeout_flag, 1'b1, "R5 set after restart");
        pulse_clr();

        // R6 / R7: disabled counting, then enable after expiry
        cur_req = "R6";
        rx_en = 1'b0;
        pulse_end(); ticks(60); idle(3);
        check(timeout_flag, 1'b0, "R6 gated while disabled");
        cur_req = "R7";
        rx_en = 1'b1; idle(1);
        check(timeout_flag, 1'b1, "R7 set on enable");

        // R9: no re-trigger after clear, through saturation
        cur_req = "R9";
        pulse_clr();
        ticks(CNT_CAP + 200); idle(2);
        check(timeout_flag, 1'b0, "R9 no retrigger");

        // R10: zero timeout, and set beats clear (R8)
        cur_req = "R10";
        timeout_bits = 8'd0;
        pulse_end(); ticks(1); idle(1);
        check(timeout_flag, 1'b0, "R10 one tick");
        pulse_end(); ticks(2);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        check(timeout_flag, 1'b1, "R10 zero timeout / R8 set beats clear");

        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule